// File: doc/BRIEF.md
# ADC Conversion Clock Generator with Sample Window Timer

This block derives the conversion clock of an analog-to-digital converter from the peripheral bus clock. A 5-bit prescale value N sets a modulo counter that wraps every N+1 bus cycles. Each wrap toggles a flip-flop, so the conversion clock is high for N+1 cycles and low for N+1 cycles. The total division is therefore 2(N+1), and the duty cycle is always 50%. The block also gives a one-cycle enable pulse on every rising edge of the conversion clock, so downstream converter logic can run on the bus clock alone.

A second part times the final sample phase of a conversion. A start strobe opens a window that lasts a selectable number of conversion-clock periods: 2, 4, 8 or 16. When the window closes, a one-cycle done pulse follows. An out-of-range flag reports prescale settings above the recommended range. Such settings still divide correctly.

Top module: `adc_clkgen`

## Requirements
- R1: For prescale value N, `cnv_clk` has a period of 2(N+1) bus cycles. It stays high for N+1 cycles and low for N+1 cycles.
- R2: With N = 0, `cnv_clk` toggles on every bus cycle, which is a total division of 2.
- R3: After reset, the divider uses the default value 1 (total division 4) until its first terminal count, whatever `presc_sel` holds. The first rising edge of `cnv_clk` follows the second bus clock edge after reset is released.
- R4: A new `presc_sel` value is taken only at the divider's next terminal count. The half period in progress completes with its old length, so no runt pulse appears.
- R5: `cnv_en` is high for exactly one bus cycle: the cycle in which `cnv_clk` has just risen. It is high in no other cycle.
- R6: `presc_oor` is 1 one cycle after `presc_sel` holds a value of 8 or more, and 0 one cycle after a value of 7 or less. Values of 8 and above still divide as R1 states.
- R7: `smp_sel` encodings 00, 01, 10 and 11 select windows of 2, 4, 8 and 16 conversion-clock periods. `smp_active` rises on the edge that samples `start`. It stays high until it has seen exactly that many `cnv_en` pulses. The selection is latched at start.
- R8: `smp_done` is a single-cycle pulse. It rises on the edge where `smp_active` falls.
- R9: A `start` that arrives while `smp_active` is high is ignored. The window length does not change and only one `smp_done` pulse follows.
- R10: While reset is high, `cnv_clk`, `cnv_en`, `smp_active` and `smp_done` are 0. Reset also clears the divider counter and the toggle flip-flop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral bus clock |
| rst | input | 1 | Synchronous active-high reset |
| presc_sel | input | 5 | Prescale value N |
| smp_sel | input | 2 | Sample window select |
| start | input | 1 | Start strobe for the sample window |
| cnv_clk | output | 1 | Conversion clock, 50% duty |
| cnv_en | output | 1 | One-cycle pulse on each conversion clock rising edge |
| smp_active | output | 1 | Sample window open |
| smp_done | output | 1 | One-cycle pulse when the window closes |
| presc_oor | output | 1 | Prescale value above the recommended range |

## Verification
The bench builds the block with its default parameters:
- a 5-bit prescale field;
- a recommended maximum of 7;
- a reset default of 1;
- a 2-bit window select.

With these values the full prescale span from 0 to 31 is reachable, which includes the out-of-range values 8 and 31 next to the boundary value 7. All four window lengths are reachable too. The longest case, a 16-period window at N = 7, and a 4-period window at N = 31 both stay within a few thousand cycles. This lets every vector measure a whole clock period and a whole sample window.

// File: rtl/adcck_pkg.sv
package adcck_pkg;

  // Window select encodings: 2, 4, 8 or 16 conversion-clock periods
  typedef enum logic [1:0] {
    WIN_2  = 2'd0,
    WIN_4  = 2'd1,
    WIN_8  = 2'd2,
    WIN_16 = 2'd3
  } win_sel_e;

  // Last count value of a window: (2 << sel) - 1, computed at width cw
  function automatic logic [15:0] win_last(input logic [3:0] sel);
    logic [16:0] len;
    len = 17'd2 << sel;
    return 16'(len - 17'd1);
  endfunction

endpackage

// File: rtl/adcck_modcnt.sv
// Modulo counter: terminal count every (ratio + 1) cycles; ratio reloads at terminal count
module adcck_modcnt #(
  parameter int W         = 5,
  parameter int RST_RATIO = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ratio,
  output logic         tc
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] lim_q;

  assign tc = (cnt_q == lim_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lim_q <= W'(RST_RATIO);
    end else if (tc) begin
      cnt_q <= '0;
      lim_q <= ratio;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/adcck_toggle.sv
// Divide-by-two stage with a registered rising-edge enable
module adcck_toggle (
  input  logic clk,
  input  logic rst,
  input  logic tc,
  output logic level,
  output logic rise_en
);

  always_ff @(posedge clk) begin
    if (rst) begin
      level   <= 1'b0;
      rise_en <= 1'b0;
    end else begin
      rise_en <= tc & ~level;
      if (tc) level <= ~level;
    end
  end

endmodule

// File: rtl/adcck_window.sv
// Sample window timer counting conversion-clock enables after a start
module adcck_window
  import adcck_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [SEL_W-1:0] sel,
  input  logic             tick,
  output logic             active,
  output logic             done
);

  localparam int CNT_W = 1 << SEL_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      done   <= 1'b0;
      cnt_q  <= '0;
      last_q <= '0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          cnt_q  <= '0;
          last_q <= CNT_W'(win_last(4'(sel)));
        end
      end else if (tick) begin
        if (cnt_q == last_q) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/adc_clkgen.sv
module adc_clkgen #(
  parameter int PRESC_W     = 5,
  parameter int MAX_OK      = 7,
  parameter int RESET_PRESC = 1,
  parameter int SEL_W       = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PRESC_W-1:0] presc_sel,
  input  logic [SEL_W-1:0]   smp_sel,
  input  logic               start,
  output logic               cnv_clk,
  output logic               cnv_en,
  output logic               smp_active,
  output logic               smp_done,
  output logic               presc_oor
);

  localparam logic [PRESC_W-1:0] OK_LIM = PRESC_W'(MAX_OK);

  logic tc;

  adcck_modcnt #(
    .W         (PRESC_W),
    .RST_RATIO (RESET_PRESC)
  ) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .ratio (presc_sel),
    .tc    (tc)
  );

  adcck_toggle u_div2 (
    .clk     (clk),
    .rst     (rst),
    .tc      (tc),
    .level   (cnv_clk),
    .rise_en (cnv_en)
  );

  adcck_window #(
    .SEL_W (SEL_W)
  ) u_win (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .sel    (smp_sel),
    .tick   (cnv_en),
    .active (smp_active),
    .done   (smp_done)
  );

  // Range flag tracks the field, also while in reset
  always_ff @(posedge clk) begin
    presc_oor <= (presc_sel > OK_LIM);
  end

endmodule

// File: rtl/adcck_chk.sv
module adcck_chk #(
  parameter int PRESC_W = 5,
  parameter int MAX_OK  = 7
) (
  input logic               clk,
  input logic               rst,
  input logic [PRESC_W-1:0] presc_sel,
  input logic               start,
  input logic               cnv_clk,
  input logic               cnv_en,
  input logic               smp_active,
  input logic               smp_done,
  input logic               presc_oor
);

  a_r5_en_on_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(cnv_clk) |-> cnv_en);

  a_r5_en_only_high: assert property (@(posedge clk) disable iff (rst)
    cnv_en |-> cnv_clk && !$past(cnv_clk));

  a_r6_range_flag: assert property (@(posedge clk) disable iff (rst)
    presc_oor == ($past(presc_sel) > PRESC_W'(MAX_OK)));

  a_r7_start_opens: assert property (@(posedge clk) disable iff (rst)
    (start && !smp_active) |=> smp_active);

  a_r8_done_at_fall: assert property (@(posedge clk) disable iff (rst)
    smp_done |-> !smp_active && $past(smp_active));

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    smp_done |=> !smp_done);

  a_r10_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> !cnv_clk && !cnv_en && !smp_active && !smp_done);

endmodule

bind adc_clkgen adcck_chk #(
  .PRESC_W (PRESC_W),
  .MAX_OK  (MAX_OK)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .presc_sel  (presc_sel),
  .start      (start),
  .cnv_clk    (cnv_clk),
  .cnv_en     (cnv_en),
  .smp_active (smp_active),
  .smp_done   (smp_done),
  .presc_oor  (presc_oor)
);

// File: tb/sim_adc_clkgen.sv
module sim_adc_clkgen;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // {presc[4:0], smp_sel[1:0], expected oor}
  localparam logic [7:0] VEC [0:NVEC-1] = '{
    {5'd0,  2'd0, 1'b0},
    {5'd1,  2'd1, 1'b0},
    {5'd3,  2'd2, 1'b0},
    {5'd7,  2'd3, 1'b0},
    {5'd8,  2'd0, 1'b1},
    {5'd31, 2'd1, 1'b1},
    {5'd5,  2'd3, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] presc_sel = 5'd5;
  logic [1:0] smp_sel = 2'd0;
  logic       start = 1'b0;
  logic       cnv_clk, cnv_en, smp_active, smp_done, presc_oor;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  adc_clkgen u0 (
    .clk(clk), .rst(rst), .presc_sel(presc_sel), .smp_sel(smp_sel),
    .start(start), .cnv_clk(cnv_clk), .cnv_en(cnv_en),
    .smp_active(smp_active), .smp_done(smp_done), .presc_oor(presc_oor)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_en();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!cnv_en && guard < 200);
  endtask

  // Measures one full period from a rising edge; returns period and high time
  task automatic measure(output int per, output int hi);
    wait_en();
    per = 0;
    hi = 1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      per++;
      if (cnv_en) break;
      if (cnv_clk) hi++;
    end
  endtask

  // Runs one sample window; optionally re-strobes start mid-window
  task automatic window(input bit inject, output int ens, output int dones,
                        output int act_at_done, output int opened);
    bit injected = 1'b0;
    ens = 0; dones = 0; act_at_done = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    opened = smp_active;
    for (int i = 0; i < 3000; i++) begin
      if (smp_active && cnv_en) ens++;
      if (smp_done) begin
        dones++;
        act_at_done = smp_active;
      end
      if (inject && !injected && ens == 1) begin
        start = 1'b1;
        injected = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (!smp_active && i > 0 && !smp_done && dones > 0) break;
      @(negedge clk);
    end
    start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (smp_done) dones++;
    end
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    int per, hi, ens, dones, aad, opened;
    // R10: outputs quiet in reset
    repeat (4) @(negedge clk);
    chk("R10 cnv_clk", cnv_clk, 0);
    chk("R10 cnv_en", cnv_en, 0);
    chk("R10 smp_active", smp_active, 0);
    chk("R10 smp_done", smp_done, 0);
    rst = 1'b0;
    // R3: default divider value 1 until the first terminal count
    @(negedge clk);
    chk("R3 clk low after first edge", cnv_clk, 0);
    @(negedge clk);
    chk("R3 clk high after second edge", cnv_clk, 1);
    chk("R5 en with first rise", cnv_en, 1);
    @(negedge clk);
    chk("R5 en single cycle", cnv_en, 0);

    // Vector table walk: R1, R2, R6, R7, R8
    for (int v = 0; v < NVEC; v++) begin
      int n, sel, oor, tgt;
      n   = int'(VEC[v][7:3]);
      sel = int'(VEC[v][2:1]);
      oor = int'(VEC[v][0]);
      tgt = 2 << sel;
      presc_sel = 5'(n);
      smp_sel = 2'(sel);
      wait_en();
      measure(per, hi);
      chk(n == 0 ? "R2 period" : "R1 period", per, 2 * (n + 1));
      chk(n == 0 ? "R2 high time" : "R1 high time", hi, n + 1);
      chk("R6 range flag", presc_oor, oor);
      window(1'b0, ens, dones, aad, opened);
      chk("R7 window opens", opened, 1);
      chk("R7 window length", ens, tgt);
      chk("R8 single done", dones, 1);
      chk("R8 active low at done", aad, 0);
    end

    // R4: change mid high phase; current half completes with old length
    presc_sel = 5'd7;
    wait_en();
    measure(per, hi);
    wait_en();
    presc_sel = 5'd0;
    hi = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (cnv_clk) hi++;
      else break;
    end
    chk("R4 old half completes", hi, 8);
    measure(per, hi);
    chk("R4 new period applied", per, 2);

    // R9: start during an active window is ignored
    presc_sel = 5'd2;
    smp_sel = 2'd1;
    wait_en();
    window(1'b1, ens, dones, aad, opened);
    chk("R9 window unchanged", ens, 4);
    chk("R9 one done", dones, 1);

    // R6: flag clears when returning into range
    presc_sel = 5'd9;
    @(negedge clk);
    chk("R6 flag set at 9", presc_oor, 1);
    presc_sel = 5'd7;
    @(negedge clk);
    chk("R6 flag clear at 7", presc_oor, 0);

    // R10: reset mid-window clears everything
    presc_sel = 5'd1;
    smp_sel = 2'd3;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R10 active cleared", smp_active, 0);
    chk("R10 clk cleared", cnv_clk, 0);
    rst = 1'b0;
    @(negedge clk);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule